// File: doc/BRIEF.md
# Core Power-Zone Sequencer

This block brings the power zone of a secondary processor core up or down in hardware. For each core it owns an 8-bit manual control word. The control word carries isolation, memory power, clock enable, reset release, manual-mode select and a power-switch enable. The block changes that word one step at a time, in a fixed order. Between certain steps it waits on per-core power-good status inputs, and every such wait is bounded by a cycle-count timeout.

A power-up request carries a core index and a start address. If the core's status says it is off, the power-on steps run first. In every case the core is then released: two boot-address words are written for that core, and its bit in a shared halt register is cleared. A power-down request first waits until the core's alive flag drops. It then walks the zone back down and finally sets the core's halt bit. Core 0 is never powered down. The requester sees `busy`, a one-cycle `done`, and a sticky `err` that is cleared by `err_clr`.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset every control word is 0, the halt vector has every bit set except bit 0, and `busy`, `done` and `err` are low.
- R2: The control word uses clock enable at bit 0, reset release at bit 1, memory power at bit 4, power-switch at bit 5, isolation at bit 6 and manual mode at bit 7. A power-up of a core that is off writes these values in this order: 0x40 (isolation set, the rest of the byte cleared), 0xC0, 0xE0, 0xF0, 0xF1, 0xB1, 0xB3.
- R3: The per-core status input has the off flag at bit 2, memory-power-good at bit 1 and digital-power-good at bit 0. Clock enable is set only after memory-power-good is seen high. Reset release is set only after digital-power-good is seen high.
- R4: The release step writes two words, one per cycle on `bw_valid`. The first goes to byte offset core×8 with data 0. The second goes to offset core×8+4 with the start address. The core's halt bit is then cleared, and `done` is high for exactly one cycle.
- R5: A power-up of a core whose off flag is clear leaves its control word unchanged and performs only the release step.
- R6: A power-down walks the control word from 0xB3 through 0xB1, 0xB0, 0xF0, 0xE0 and then, after memory-power-good is low, 0xC0. After digital-power-good is low, it sets the core's halt bit.
- R7: While the target core's alive flag is set, a power-down holds `busy` and changes no control bit.
- R8: A power-down request for core 0 is refused. `busy` stays low, and no control bit and no halt bit changes.
- R9: A wait that fails samples the status once per cycle for TIMEOUT_CYC+1 cycles. On the last failed sample `err` rises, the sequence stops with the control word left as it is, and no `done` is given.
- R10: `err` stays high until `err_clr` is pulsed.
- R11: A request that arrives while `busy` is high is ignored.
- R12: `busy` is high from the cycle after an accepted request until the cycle in which `done` or `err` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_up | input | 1 | Power-up and release request pulse |
| req_down | input | 1 | Power-down request pulse |
| req_core | input | CORE_W | Target core index |
| boot_addr | input | ADDR_W | Start address for the release step |
| err_clr | input | 1 | Clears the sticky error |
| core_alive | input | NUM_CORES | Per-core alive flags |
| zone_status | input | NUM_CORES*3 | Per-core status: bit 2 off, bit 1 memory-power-good, bit 0 digital-power-good |
| zone_ctrl | output | NUM_CORES*8 | Per-core manual control words |
| core_halt | output | NUM_CORES | Per-core halt bits |
| bw_valid | output | 1 | Boot-address word write strobe |
| bw_ofs | output | CORE_W+3 | Byte offset of the boot-address word |
| bw_data | output | ADDR_W | Boot-address word data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout error |

## Verification
The hardest condition to reach from the ports is a timeout that lands on the exact cycle of the final status sample. It needs a status input that never answers, and the error cycle must be counted from the accepting edge. The bench models each core's power-good responses as delayed copies of its control bits. A per-core stuck override holds memory-power-good low, and the bench then checks that `err` is still low one cycle before the computed edge and high just after it. The alive-flag hold and the busy-time request are reached by driving those inputs during a sequence that is known to be in progress.

// File: rtl/pwr_seq_pkg.sv
// Shared constants and state type for the core power-zone sequencer.
// Assumes an 8-bit control word and a 3-bit status nibble per core.
package pwr_seq_pkg;
    localparam int CTRL_W = 8;
    localparam int STAT_W = 3;

    // Control word bit positions (decoded by the power-zone hardware)
    localparam int CB_CLK = 0;
    localparam int CB_RST = 1;
    localparam int CB_MEM = 4;
    localparam int CB_PSW = 5;
    localparam int CB_ISO = 6;
    localparam int CB_MAN = 7;

    // Status nibble bit positions
    localparam int SB_DPG = 0;
    localparam int SB_MEM = 1;
    localparam int SB_OFF = 2;

    typedef enum logic [4:0] {
        S_IDLE,
        S_U_ISO, S_U_MAN, S_U_PSW, S_U_MEM, S_U_WMEM,
        S_U_CLK, S_U_WDPG, S_U_DEISO, S_U_RST,
        S_B_HI, S_B_LO, S_B_REL,
        S_D_ALIVE, S_D_MAN, S_D_RST, S_D_CLK, S_D_ISO,
        S_D_MEM, S_D_WMEM, S_D_PSW, S_D_WDPG, S_D_HALT
    } seq_state_e;

    function automatic logic [CTRL_W-1:0] cbit(input int pos);
        return CTRL_W'(1) << pos;
    endfunction
endpackage

// File: rtl/pwr_wait_timer.sv
// Wait timer: counts cycles while run is high and flags the final sample.
// Assumes the sequencer drops run for at least one cycle between waits.
module pwr_wait_timer #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    assign expired = (cnt == CNT_W'(TIMEOUT_CYC));

    // Count up while waiting, hold at the limit, restart when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_ctrl_regs.sv
// Per-core control words and the shared halt vector.
// Assumes at most one control write and one halt update per cycle.
module pwr_ctrl_regs
    import pwr_seq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = $clog2(NUM_CORES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CORE_W-1:0]           wr_core,
    input  logic                        ctl_we,
    input  logic [CTRL_W-1:0]           ctl_set,
    input  logic [CTRL_W-1:0]           ctl_clr,
    input  logic                        halt_set,
    input  logic                        halt_clr,
    output logic [NUM_CORES*CTRL_W-1:0] zone_ctrl,
    output logic [NUM_CORES-1:0]        core_halt
);
    localparam logic [NUM_CORES-1:0] HALT_RST = {{(NUM_CORES-1){1'b1}}, 1'b0};

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [CTRL_W-1:0] word_q;
        // Apply clear mask then set mask to the addressed core's word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (ctl_we && (wr_core == CORE_W'(c))) begin
                word_q <= (word_q & ~ctl_clr) | ctl_set;
            end
        end
        assign zone_ctrl[c*CTRL_W +: CTRL_W] = word_q;
    end

    // Halt vector: secondaries start halted, bit updated per request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_halt <= HALT_RST;
        end else if (halt_set) begin
            core_halt[wr_core] <= 1'b1;
        end else if (halt_clr) begin
            core_halt[wr_core] <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
// Step sequencer: one state per control write or status wait.
// Assumes status inputs are already synchronous to clk.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W = 32,
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int OFS_W = CORE_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_up,
    input  logic              req_down,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] boot_addr,
    input  logic              err_clr,
    input  logic              st_off,
    input  logic              st_mem,
    input  logic              st_dpg,
    input  logic              alive_sel,
    input  logic              tmr_expired,
    output logic [CORE_W-1:0] sel_core,
    output logic              tmr_run,
    output logic              ctl_we,
    output logic [CTRL_W-1:0] ctl_set,
    output logic [CTRL_W-1:0] ctl_clr,
    output logic              halt_set,
    output logic              halt_clr,
    output logic              bw_valid,
    output logic [OFS_W-1:0]  bw_ofs,
    output logic [ADDR_W-1:0] bw_data,
    output logic              busy,
    output logic              done,
    output logic              err
);
    seq_state_e        state, nxt;
    logic [CORE_W-1:0] core_q;
    logic [ADDR_W-1:0] addr_q;
    logic              bw_hi, fin, tout, accept;

    assign busy     = (state != S_IDLE);
    assign sel_core = busy ? core_q : req_core;
    assign accept   = !busy && (req_up || (req_down && req_core != '0));
    assign bw_ofs   = {core_q, bw_hi, 2'b00};
    assign bw_data  = bw_hi ? addr_q : '0;

    // Next state and per-step control operation
    always_comb begin
        nxt = state; ctl_we = 1'b0; ctl_set = '0; ctl_clr = '0;
        halt_set = 1'b0; halt_clr = 1'b0; bw_valid = 1'b0; bw_hi = 1'b0;
        tmr_run = 1'b0; tout = 1'b0; fin = 1'b0;
        case (state)
            S_IDLE: begin
                if (req_up)                         nxt = st_off ? S_U_ISO : S_B_HI;
                else if (req_down && req_core != '0) nxt = S_D_ALIVE;
            end
            S_U_ISO:   begin ctl_we = 1'b1; ctl_set = cbit(CB_ISO); ctl_clr = '1; nxt = S_U_MAN; end
            S_U_MAN:   begin ctl_we = 1'b1; ctl_set = cbit(CB_MAN); nxt = S_U_PSW; end
            S_U_PSW:   begin ctl_we = 1'b1; ctl_set = cbit(CB_PSW); nxt = S_U_MEM; end
            S_U_MEM:   begin ctl_we = 1'b1; ctl_set = cbit(CB_MEM); nxt = S_U_WMEM; end
            S_U_WMEM: begin
                tmr_run = 1'b1;
                if (st_mem)           nxt = S_U_CLK;
                else if (tmr_expired) begin tout = 1'b1; nxt = S_IDLE; end
            end
            S_U_CLK:   begin ctl_we = 1'b1; ctl_set = cbit(CB_CLK); nxt = S_U_WDPG; end
            S_U_WDPG: begin
                tmr_run = 1'b1;
                if (st_dpg)           nxt = S_U_DEISO;
                else if (tmr_expired) begin tout = 1'b1; nxt = S_IDLE; end
            end
            S_U_DEISO: begin ctl_we = 1'b1; ctl_clr = cbit(CB_ISO); nxt = S_U_RST; end
            S_U_RST:   begin ctl_we = 1'b1; ctl_set = cbit(CB_RST); nxt = S_B_HI; end
            S_B_HI:    begin bw_valid = 1'b1; nxt = S_B_LO; end
            S_B_LO:    begin bw_valid = 1'b1; bw_hi = 1'b1; nxt = S_B_REL; end
            S_B_REL:   begin halt_clr = 1'b1; fin = 1'b1; nxt = S_IDLE; end
            S_D_ALIVE: if (!alive_sel) nxt = S_D_MAN;
            S_D_MAN:   begin ctl_we = 1'b1; ctl_set = cbit(CB_MAN); nxt = S_D_RST; end
            S_D_RST:   begin ctl_we = 1'b1; ctl_clr = cbit(CB_RST); nxt = S_D_CLK; end
            S_D_CLK:   begin ctl_we = 1'b1; ctl_clr = cbit(CB_CLK); nxt = S_D_ISO; end
            S_D_ISO:   begin ctl_we = 1'b1; ctl_set = cbit(CB_ISO); nxt = S_D_MEM; end
            S_D_MEM:   begin ctl_we = 1'b1; ctl_clr = cbit(CB_MEM); nxt = S_D_WMEM; end
            S_D_WMEM: begin
                tmr_run = 1'b1;
                if (!st_mem)          nxt = S_D_PSW;
                else if (tmr_expired) begin tout = 1'b1; nxt = S_IDLE; end
            end
            S_D_PSW:   begin ctl_we = 1'b1; ctl_clr = cbit(CB_PSW); nxt = S_D_WDPG; end
            S_D_WDPG: begin
                tmr_run = 1'b1;
                if (!st_dpg)          nxt = S_D_HALT;
                else if (tmr_expired) begin tout = 1'b1; nxt = S_IDLE; end
            end
            S_D_HALT:  begin halt_set = 1'b1; fin = 1'b1; nxt = S_IDLE; end
            default:   nxt = S_IDLE;
        endcase
    end

    // State, captured request and completion/error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            core_q <= '0;
            addr_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                core_q <= req_core;
                addr_q <= boot_addr;
            end
            done <= fin;
            if (tout)         err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end
endmodule

// File: rtl/core_pwr_seq.sv
// Top of the core power-zone sequencer: joins the step sequencer, the
// wait timer and the control registers; selects the target core's status.
// Assumes zone_status and core_alive are synchronous to clk.
module core_pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W = 32,
    parameter int TIMEOUT_CYC = 1000,
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int OFS_W = CORE_W + 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_up,
    input  logic                        req_down,
    input  logic [CORE_W-1:0]           req_core,
    input  logic [ADDR_W-1:0]           boot_addr,
    input  logic                        err_clr,
    input  logic [NUM_CORES-1:0]        core_alive,
    input  logic [NUM_CORES*STAT_W-1:0] zone_status,
    output logic [NUM_CORES*CTRL_W-1:0] zone_ctrl,
    output logic [NUM_CORES-1:0]        core_halt,
    output logic                        bw_valid,
    output logic [OFS_W-1:0]            bw_ofs,
    output logic [ADDR_W-1:0]           bw_data,
    output logic                        busy,
    output logic                        done,
    output logic                        err
);
    logic [CORE_W-1:0] sel_core;
    logic [STAT_W-1:0] st_sel;
    logic              tmr_run, tmr_expired;
    logic              ctl_we, halt_set, halt_clr;
    logic [CTRL_W-1:0] ctl_set, ctl_clr;

    assign st_sel = zone_status[int'(sel_core)*STAT_W +: STAT_W];

    pwr_seq_fsm #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_down(req_down),
        .req_core(req_core), .boot_addr(boot_addr), .err_clr(err_clr),
        .st_off(st_sel[SB_OFF]), .st_mem(st_sel[SB_MEM]), .st_dpg(st_sel[SB_DPG]),
        .alive_sel(core_alive[sel_core]), .tmr_expired(tmr_expired),
        .sel_core(sel_core), .tmr_run(tmr_run), .ctl_we(ctl_we),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr), .halt_set(halt_set),
        .halt_clr(halt_clr), .bw_valid(bw_valid), .bw_ofs(bw_ofs),
        .bw_data(bw_data), .busy(busy), .done(done), .err(err)
    );

    pwr_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_expired)
    );

    pwr_ctrl_regs #(.NUM_CORES(NUM_CORES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_core(sel_core), .ctl_we(ctl_we),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr), .halt_set(halt_set),
        .halt_clr(halt_clr), .zone_ctrl(zone_ctrl), .core_halt(core_halt)
    );
endmodule

// File: rtl/core_pwr_seq_chk.sv
// Property checker for core_pwr_seq, attached by bind.
module core_pwr_seq_chk
    import pwr_seq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = $clog2(NUM_CORES)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_up,
    input logic                        req_down,
    input logic [CORE_W-1:0]           req_core,
    input logic                        err_clr,
    input logic [NUM_CORES*STAT_W-1:0] zone_status,
    input logic [NUM_CORES*CTRL_W-1:0] zone_ctrl,
    input logic [NUM_CORES-1:0]        core_halt,
    input logic                        busy,
    input logic                        done,
    input logic                        err
);
    // R8: a down request for core 0 never starts a sequence
    a_r8_core0_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_down && !req_up && req_core == '0 && !busy) |=> !busy);

    // R10: the error flag holds until cleared
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    // R4: completion is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: completion is never reported while a sequence runs
    a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: an on core's up request writes no control bit
    a_r5_skip_on_core: assert property (@(posedge clk) disable iff (!rst_n)
        (req_up && !busy && !zone_status[int'(req_core)*STAT_W + SB_OFF])
        |=> ##1 $stable(zone_ctrl));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        // R3: clock enable rises only with memory power good
        a_r3_clk_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(zone_ctrl[c*CTRL_W + CB_CLK]) |-> zone_status[c*STAT_W + SB_MEM]);
        // R3: reset release rises only with digital power good
        a_r3_rst_after_dpg: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(zone_ctrl[c*CTRL_W + CB_RST]) |-> zone_status[c*STAT_W + SB_DPG]);
        // R6: halt is set only once the power switch is off
        a_r6_halt_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_halt[c]) |-> !zone_ctrl[c*CTRL_W + CB_PSW]);
    end
endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_down(req_down),
    .req_core(req_core), .err_clr(err_clr), .zone_status(zone_status),
    .zone_ctrl(zone_ctrl), .core_halt(core_halt), .busy(busy),
    .done(done), .err(err)
);

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;
    localparam int NC = 4;
    localparam int AW = 32;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_up = 1'b0, req_down = 1'b0, err_clr = 1'b0;
    logic [1:0] req_core = '0;
    logic [AW-1:0] boot_addr = '0;
    logic [NC-1:0] core_alive = '0;
    logic [NC*3-1:0] zone_status;
    logic [NC*8-1:0] zone_ctrl;
    logic [NC-1:0] core_halt;
    logic bw_valid, busy, done, err;
    logic [4:0] bw_ofs;
    logic [AW-1:0] bw_data;

    int n_chk = 0, n_fail = 0;
    logic [NC-1:0] stuck_mem = '0;
    logic [2:0] mem_sh [NC];
    logic [2:0] dpg_sh [NC];

    always #2 clk = ~clk;

    core_pwr_seq #(.NUM_CORES(NC), .ADDR_W(AW), .TIMEOUT_CYC(TO)) u_core_pwr_seq (
        .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_down(req_down),
        .req_core(req_core), .boot_addr(boot_addr), .err_clr(err_clr),
        .core_alive(core_alive), .zone_status(zone_status), .zone_ctrl(zone_ctrl),
        .core_halt(core_halt), .bw_valid(bw_valid), .bw_ofs(bw_ofs),
        .bw_data(bw_data), .busy(busy), .done(done), .err(err)
    );

    // Power-zone model: power-good follows control bits three cycles late
    for (genvar c = 0; c < NC; c++) begin : g_model
        always @(posedge clk) begin
            mem_sh[c] <= {mem_sh[c][1:0], zone_ctrl[c*8+4]};
            dpg_sh[c] <= {dpg_sh[c][1:0], zone_ctrl[c*8+5] & zone_ctrl[c*8+0]};
        end
        assign zone_status[c*3+2] = ~zone_ctrl[c*8+1];
        assign zone_status[c*3+1] = mem_sh[c][2] & ~stuck_mem[c];
        assign zone_status[c*3+0] = dpg_sh[c][2];
    end

    // Monitors: control-word history of one core, boot writes, done cycles
    int watch = 1;
    logic [7:0] hist [16];
    int hn = 0, bn = 0, done_n = 0;
    logic [7:0] prev_w = '0;
    logic [4:0] b_ofs [4];
    logic [AW-1:0] b_dat [4];
    logic order_bad = 1'b0;
    always @(posedge clk) begin
        logic [7:0] cur;
        cur = zone_ctrl[watch*8 +: 8];
        if (cur != prev_w) begin
            if (hn < 16) hist[hn] = cur;
            hn++;
            if (cur[0] && !prev_w[0] && !zone_status[watch*3+1]) order_bad = 1'b1;
            if (cur[1] && !prev_w[1] && !zone_status[watch*3+0]) order_bad = 1'b1;
        end
        prev_w = cur;
        if (bw_valid) begin
            if (bn < 4) begin b_ofs[bn] = bw_ofs; b_dat[bn] = bw_data; end
            bn++;
        end
        if (done) done_n++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon(input int core);
        @(negedge clk);
        watch = core; prev_w = zone_ctrl[core*8 +: 8];
        hn = 0; bn = 0; done_n = 0; order_bad = 1'b0;
    endtask

    task automatic pulse(input bit up, input int core, input logic [AW-1:0] addr);
        @(negedge clk);
        req_up = up; req_down = !up; req_core = 2'(core); boot_addr = addr;
        @(negedge clk);
        req_up = 1'b0; req_down = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_hist(input string req, input logic [7:0] exp [], input int n);
        chk(hn == n, req, hn, n);
        for (int i = 0; i < n && i < hn; i++) chk(hist[i] == exp[i], req, hist[i], exp[i]);
    endtask

    task automatic t_reset();
        chk(zone_ctrl == '0, "R1", zone_ctrl, 0);
        chk(core_halt == 4'b1110, "R1", core_halt, 4'b1110);
        chk({busy, done, err} == 3'b000, "R1", {busy, done, err}, 0);
    endtask

    task automatic t_power_up();
        logic [7:0] e [] = '{8'h40, 8'hC0, 8'hE0, 8'hF0, 8'hF1, 8'hB1, 8'hB3};
        clear_mon(1);
        pulse(1'b1, 1, 32'h8000_1000);
        chk(busy == 1'b1, "R12", busy, 1);
        pulse(1'b0, 3, 32'h0);           // R11: arrives while busy
        wait_idle();
        chk_hist("R2", e, 7);
        chk(!order_bad, "R3", order_bad, 0);
        chk(bn == 2, "R4", bn, 2);
        chk(b_ofs[0] == 5'd8 && b_dat[0] == '0, "R4", {b_ofs[0], b_dat[0]}, {5'd8, 32'h0});
        chk(b_ofs[1] == 5'd12 && b_dat[1] == 32'h8000_1000, "R4", b_dat[1], 32'h8000_1000);
        chk(core_halt[1] == 1'b0, "R4", core_halt[1], 0);
        chk(done_n == 1, "R4", done_n, 1);
        chk(zone_ctrl[31:24] == 8'h00 && core_halt[3], "R11", zone_ctrl[31:24], 0);
    endtask

    task automatic t_skip_on();
        clear_mon(1);
        pulse(1'b1, 1, 32'h0000_2000);
        wait_idle();
        chk(hn == 0, "R5", hn, 0);
        chk(bn == 2 && b_dat[1] == 32'h0000_2000, "R5", b_dat[1], 32'h2000);
        chk(done_n == 1, "R5", done_n, 1);
    endtask

    task automatic t_power_down();
        logic [7:0] e [] = '{8'hB1, 8'hB0, 8'hF0, 8'hE0, 8'hC0};
        clear_mon(1);
        core_alive[1] = 1'b1;
        pulse(1'b0, 1, 32'h0);
        repeat (30) @(negedge clk);
        chk(busy == 1'b1, "R7", busy, 1);
        chk(zone_ctrl[15:8] == 8'hB3, "R7", zone_ctrl[15:8], 8'hB3);
        core_alive[1] = 1'b0;
        wait_idle();
        chk_hist("R6", e, 5);
        chk(core_halt[1] == 1'b1, "R6", core_halt[1], 1);
        chk(done_n == 1, "R6", done_n, 1);
    endtask

    task automatic t_core0();
        clear_mon(0);
        pulse(1'b1, 0, 32'h0);
        wait_idle();
        chk(zone_ctrl[7:0] == 8'hB3, "R2", zone_ctrl[7:0], 8'hB3);
        clear_mon(0);
        pulse(1'b0, 0, 32'h0);
        chk(busy == 1'b0, "R8", busy, 0);
        repeat (10) @(negedge clk);
        chk(hn == 0 && zone_ctrl[7:0] == 8'hB3, "R8", zone_ctrl[7:0], 8'hB3);
        chk(core_halt[0] == 1'b0 && done_n == 0, "R8", {core_halt[0], done_n[0]}, 0);
    endtask

    task automatic t_timeout();
        clear_mon(2);
        stuck_mem[2] = 1'b1;
        pulse(1'b1, 2, 32'h0);           // accepting edge is E0
        repeat (20) @(posedge clk);      // E20
        @(negedge clk);
        chk(err == 1'b0, "R9", err, 0);
        @(negedge clk);                  // after E21
        chk(err == 1'b1, "R9", err, 1);
        chk(busy == 1'b0, "R12", busy, 0);
        chk(zone_ctrl[23:16] == 8'hF0, "R9", zone_ctrl[23:16], 8'hF0);
        repeat (5) @(negedge clk);
        chk(err == 1'b1 && done_n == 0, "R10", err, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(err == 1'b0, "R10", err, 0);
        stuck_mem[2] = 1'b0;
        pulse(1'b1, 2, 32'h0000_3000);
        wait_idle();
        chk(zone_ctrl[23:16] == 8'hB3 && !err, "R9", zone_ctrl[23:16], 8'hB3);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_power_up();
        t_skip_on();
        t_power_down();
        t_core0();
        t_timeout();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule